// File: doc/BRIEF.md
# Pixel to Parallel Bus Packer

This block turns a stream of pixels into write cycles on a narrow parallel display bus. Software or a neighbouring block chooses a pixel depth, a bus width and a pixel count, then pulses a start input. The block reads the chosen number of pixels through a valid/ready handshake. It splits each pixel, or each pair of pixels, into one to three bus words. When the last word has left it raises a one-cycle frame-done pulse. The number of bus cycles per pixel group follows from the ratio of pixel depth to bus width. The 3:2 case packs two pixels into three words by splitting the middle word into two half-width pieces.

When no frame is running, single command words and parameter words can be written to the bus through two separate strobed inputs. An address/data-select flag on the bus tells them apart. Pixel words always carry the data setting of that flag. A depth/width pair with no valid cycle format is refused, and the refusal is recorded in a sticky error flag. Strobe timing and tearing sync live in other blocks.

Top module: `pix_bus_packer`

## Requirements
- R1: Depth code 0/1/2/3 selects 12/16/18/24 bits and width code 0/1/2/3 selects 8/9/12/16 lines. A pair is valid when the depth equals one, two or three times the width (one, two or three words per pixel) or when twice the depth equals three times the width (three words per two pixels). Bus words sit on busData bits width-1:0 with the upper bits zero.
- R2: In the one-pixel formats the pixel's bits depth-1:0 leave as width-sized chunks, most significant chunk first. For 16 bits on 8 lines that is 15:8 then 7:0. For 24 bits on 8 lines it is 23:16, 15:8, 7:0.
- R3: In the two-pixel format with pixels A then B, word 1 holds the top width bits of A. Word 2 holds the low width/2 bits of A in its upper half and the top width/2 bits of B in its lower half. Word 3 holds the low width bits of B.
- R4: In the two-pixel format an odd pixel count ends with a group in which the missing second pixel is taken as zero, and all three words are sent.
- R5: Pixel input bits at and above the selected depth have no effect on the bus words.
- R6: A start pulse while idle, with a valid pair and a non-zero count, makes busy high from the next cycle. Depth, width and count are captured at that start, and later changes to those inputs have no effect on the running frame.
- R7: A frame ends after exactly the captured number of pixels. frameDone is high for one cycle, in the cycle after the final pixel word, and busy falls in that same cycle.
- R8: A start pulse while idle with an invalid pair sets cfgErr, starts no transfer and leaves busy low. cfgErr stays high until reset.
- R9: A start pulse while idle with a zero count has no effect: busy stays low and no frameDone occurs.
- R10: While idle, cmdValid produces one bus write in the next cycle with busDc=0, and parValid produces one with busDc=1. The word is masked to the current width input. When both strobes are high only the command is sent. Pixel words always have busDc=1.
- R11: Command and parameter strobes are ignored while busy and in the cycle in which a start is accepted.
- R12: pixReady is low while idle. A pixel is taken in a cycle where pixValid and pixReady are both high.
- R13: During and just after reset, busWr, busy, frameDone, cfgErr and pixReady are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| depthCode | input | 2 | Pixel depth code |
| widthCode | input | 2 | Bus width code |
| pixCount | input | CNT_W | Pixels in the frame |
| startPulse | input | 1 | Starts a frame when idle |
| pixValid | input | 1 | Pixel input valid |
| pixData | input | PIX_W | Pixel value, right-aligned |
| pixReady | output | 1 | Block accepts a pixel |
| cmdValid | input | 1 | Command word strobe |
| cmdWord | input | BUS_W | Command word |
| parValid | input | 1 | Parameter word strobe |
| parWord | input | BUS_W | Parameter word |
| busWr | output | 1 | Bus write cycle this clock |
| busData | output | BUS_W | Bus word |
| busDc | output | 1 | 0 = command, 1 = data or parameter |
| busy | output | 1 | Frame in progress |
| frameDone | output | 1 | One-cycle end-of-frame pulse |
| cfgErr | output | 1 | Sticky invalid-configuration flag |

## Verification
The assertions assume that start pulses arrive only as single-cycle strobes. They also assume that the bus side takes one word every cycle with no back-pressure. On that basis they check that busy can only rise right after a start, and that a command word is never interleaved with a frame. The stimulus holds pixData steady while pixValid waits for pixReady, and it raises the command strobes only for single cycles. It also changes the configuration inputs in the middle of a frame, to show that the captured values rule.

// File: rtl/pix_bus_packer_pkg.sv
package pix_bus_packer_pkg;

  typedef enum logic [1:0] {
    FMT_1TO1 = 2'd0,
    FMT_2TO1 = 2'd1,
    FMT_3TO1 = 2'd2,
    FMT_3TO2 = 2'd3
  } cycFmt_t;

  typedef struct packed {
    logic    ok;
    cycFmt_t fmt;
  } fmtInfo_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadA;
    logic loadB;
    logic shift;
    logic cmdLoad;
    logic selParam;
    logic emitPix;
  } dpCtl_t;

  function automatic logic [4:0] depthBits(logic [1:0] code);
    case (code)
      2'd0:    return 5'd12;
      2'd1:    return 5'd16;
      2'd2:    return 5'd18;
      default: return 5'd24;
    endcase
  endfunction

  function automatic logic [4:0] widthBits(logic [1:0] code);
    case (code)
      2'd0:    return 5'd8;
      2'd1:    return 5'd9;
      2'd2:    return 5'd12;
      default: return 5'd16;
    endcase
  endfunction

  function automatic fmtInfo_t decodeFmt(logic [1:0] dCode, logic [1:0] wCode);
    logic [6:0] d;
    logic [6:0] w;
    fmtInfo_t   r;
    d = {2'b00, depthBits(dCode)};
    w = {2'b00, widthBits(wCode)};
    r = '{ok: 1'b0, fmt: FMT_1TO1};
    if (d == w)                      r = '{ok: 1'b1, fmt: FMT_1TO1};
    else if (d == (w << 1))          r = '{ok: 1'b1, fmt: FMT_2TO1};
    else if (d == ((w << 1) + w))    r = '{ok: 1'b1, fmt: FMT_3TO1};
    else if ((d << 1) == ((w << 1) + w)) r = '{ok: 1'b1, fmt: FMT_3TO2};
    return r;
  endfunction

endpackage

// File: rtl/pix_bus_packer_ctrl.sv
module pix_bus_packer_ctrl
  import pix_bus_packer_pkg::*;
#(
  parameter int CNT_W = 22
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [1:0]       depthCode,
  input  logic [1:0]       widthCode,
  input  logic [CNT_W-1:0] pixCount,
  input  logic             pixValid,
  output logic             pixReady,
  input  logic             cmdValid,
  input  logic             parValid,
  output dpCtl_t           ctl,
  output logic [1:0]       frameDepth,
  output logic [1:0]       frameWidth,
  output logic             busy,
  output logic             frameDone,
  output logic             cfgErr
);

  typedef enum logic [1:0] {S_IDLE, S_FETCH_A, S_FETCH_B, S_EMIT} state_t;

  state_t           state;
  logic [CNT_W-1:0] pixLeft;
  logic [1:0]       cycLeft;
  cycFmt_t          fmtQ;
  logic             doneQ;
  logic             errQ;

  fmtInfo_t liveFmt;
  logic     idle, startOk, lastCyc, accept, takeA, takeB, needB, cmdTake;
  logic [1:0] grpCyc;

  assign liveFmt = decodeFmt(depthCode, widthCode);
  assign idle    = (state == S_IDLE);
  assign startOk = idle && startPulse && liveFmt.ok && (pixCount != '0);
  assign lastCyc = (state == S_EMIT) && (cycLeft == 2'd1);

  assign pixReady = (state == S_FETCH_A) || (state == S_FETCH_B) ||
                    (lastCyc && (pixLeft != '0));
  assign accept   = pixValid && pixReady;
  assign takeA    = accept && (state != S_FETCH_B);
  assign takeB    = accept && (state == S_FETCH_B);

  assign grpCyc = (fmtQ == FMT_1TO1) ? 2'd1 :
                  (fmtQ == FMT_2TO1) ? 2'd2 : 2'd3;
  assign needB  = (fmtQ == FMT_3TO2) && (pixLeft > CNT_W'(1));
  assign cmdTake = idle && !startPulse && (cmdValid || parValid);

  assign ctl.loadA    = takeA;
  assign ctl.loadB    = takeB;
  assign ctl.shift    = (state == S_EMIT);
  assign ctl.cmdLoad  = cmdTake;
  assign ctl.selParam = !cmdValid;
  assign ctl.emitPix  = (state == S_EMIT);

  assign busy      = !idle;
  assign frameDone = doneQ;
  assign cfgErr    = errQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      pixLeft    <= '0;
      cycLeft    <= 2'd0;
      fmtQ       <= FMT_1TO1;
      frameDepth <= 2'd0;
      frameWidth <= 2'd0;
      doneQ      <= 1'b0;
      errQ       <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (idle && startPulse && !liveFmt.ok) errQ <= 1'b1;
      case (state)
        S_IDLE: begin
          if (startOk) begin
            fmtQ       <= liveFmt.fmt;
            frameDepth <= depthCode;
            frameWidth <= widthCode;
            pixLeft    <= pixCount;
            state      <= S_FETCH_A;
          end
        end
        S_FETCH_B: begin
          if (takeB) begin
            pixLeft <= pixLeft - CNT_W'(1);
            cycLeft <= 2'd3;
            state   <= S_EMIT;
          end
        end
        S_EMIT: begin
          cycLeft <= cycLeft - 2'd1;
          if (lastCyc && (pixLeft == '0)) begin
            state <= S_IDLE;
            doneQ <= 1'b1;
          end else if (lastCyc && !takeA) begin
            state <= S_FETCH_A;
          end
        end
        default: ;
      endcase
      // first pixel of a group, from fetch or overlapped with the last word
      if (takeA) begin
        pixLeft <= pixLeft - CNT_W'(1);
        cycLeft <= grpCyc;
        state   <= needB ? S_FETCH_B : S_EMIT;
      end
    end
  end

endmodule

// File: rtl/pix_bus_packer_dp.sv
module pix_bus_packer_dp
  import pix_bus_packer_pkg::*;
#(
  parameter int PIX_W = 24,
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic [1:0]       frameDepth,
  input  logic [1:0]       frameWidth,
  input  logic [1:0]       liveWidth,
  input  logic [PIX_W-1:0] pixData,
  input  logic [BUS_W-1:0] cmdWord,
  input  logic [BUS_W-1:0] parWord,
  output logic             busWr,
  output logic [BUS_W-1:0] busData,
  output logic             busDc
);

  localparam int GRP_W = 2 * PIX_W;
  localparam int SHW   = $clog2(GRP_W) + 1;

  logic [GRP_W-1:0] grp;
  logic [BUS_W-1:0] cmdReg;
  logic             cmdDc;
  logic             cmdOut;

  logic [4:0]       dBits, wBits, lwBits;
  logic [PIX_W-1:0] pixMask;
  logic [SHW-1:0]   alignSh, topSh;
  logic [GRP_W-1:0] alignedA, alignedB, chunkFull;
  logic [BUS_W-1:0] pixWord, srcWord, liveMask;

  assign dBits  = depthBits(frameDepth);
  assign wBits  = widthBits(frameWidth);
  assign lwBits = widthBits(liveWidth);

  // left-align the pixel in the group register; B sits right below A
  assign pixMask  = ~({PIX_W{1'b1}} << dBits);
  assign alignSh  = SHW'(PIX_W) - SHW'(dBits);
  assign alignedA = {(pixData & pixMask), {PIX_W{1'b0}}} << alignSh;
  assign alignedB = alignedA >> dBits;

  // the current bus word is the top width bits of the group
  assign topSh     = SHW'(GRP_W) - SHW'(wBits);
  assign chunkFull = grp >> topSh;
  assign pixWord   = chunkFull[BUS_W-1:0];

  assign liveMask = ~({BUS_W{1'b1}} << lwBits);
  assign srcWord  = ctl.selParam ? parWord : cmdWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grp    <= '0;
      cmdReg <= '0;
      cmdDc  <= 1'b0;
      cmdOut <= 1'b0;
    end else begin
      cmdOut <= ctl.cmdLoad;
      if (ctl.cmdLoad) begin
        cmdReg <= srcWord & liveMask;
        cmdDc  <= ctl.selParam;
      end
      if (ctl.loadA)      grp <= alignedA;
      else if (ctl.loadB) grp <= grp | alignedB;
      else if (ctl.shift) grp <= grp << wBits;
    end
  end

  assign busWr   = ctl.emitPix | cmdOut;
  assign busData = ctl.emitPix ? pixWord : (cmdOut ? cmdReg : '0);
  assign busDc   = ctl.emitPix | (cmdOut & cmdDc);

endmodule

// File: rtl/pix_bus_packer.sv
module pix_bus_packer
  import pix_bus_packer_pkg::*;
#(
  parameter int PIX_W = 24,
  parameter int BUS_W = 16,
  parameter int CNT_W = 22
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       depthCode,
  input  logic [1:0]       widthCode,
  input  logic [CNT_W-1:0] pixCount,
  input  logic             startPulse,
  input  logic             pixValid,
  input  logic [PIX_W-1:0] pixData,
  output logic             pixReady,
  input  logic             cmdValid,
  input  logic [BUS_W-1:0] cmdWord,
  input  logic             parValid,
  input  logic [BUS_W-1:0] parWord,
  output logic             busWr,
  output logic [BUS_W-1:0] busData,
  output logic             busDc,
  output logic             busy,
  output logic             frameDone,
  output logic             cfgErr
);

  dpCtl_t     ctl;
  logic [1:0] frameDepth;
  logic [1:0] frameWidth;

  pix_bus_packer_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .depthCode  (depthCode),
    .widthCode  (widthCode),
    .pixCount   (pixCount),
    .pixValid   (pixValid),
    .pixReady   (pixReady),
    .cmdValid   (cmdValid),
    .parValid   (parValid),
    .ctl        (ctl),
    .frameDepth (frameDepth),
    .frameWidth (frameWidth),
    .busy       (busy),
    .frameDone  (frameDone),
    .cfgErr     (cfgErr)
  );

  pix_bus_packer_dp #(.PIX_W(PIX_W), .BUS_W(BUS_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .frameDepth (frameDepth),
    .frameWidth (frameWidth),
    .liveWidth  (widthCode),
    .pixData    (pixData),
    .cmdWord    (cmdWord),
    .parWord    (parWord),
    .busWr      (busWr),
    .busData    (busData),
    .busDc      (busDc)
  );

endmodule

// File: rtl/pix_bus_packer_chk.sv
module pix_bus_packer_chk (
  input logic clk,
  input logic rstN,
  input logic startPulse,
  input logic pixReady,
  input logic busWr,
  input logic busDc,
  input logic busy,
  input logic frameDone,
  input logic cfgErr
);

  // R12
  idle_no_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !pixReady);

  // R7
  done_after_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> ($past(busWr) && !busy));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(cfgErr) |-> cfgErr);

  // R6
  busy_from_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startPulse));

  // R11
  cmd_only_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && !busDc) |-> !busy);

  // R10
  frame_word_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busy) |-> busDc);

endmodule

bind pix_bus_packer pix_bus_packer_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .startPulse (startPulse),
  .pixReady   (pixReady),
  .busWr      (busWr),
  .busDc      (busDc),
  .busy       (busy),
  .frameDone  (frameDone),
  .cfgErr     (cfgErr)
);

// File: tb/pix_bus_packer_tb.sv
`timescale 1ns/1ps
module pix_bus_packer_tb;

  localparam int PIX_W = 24;
  localparam int BUS_W = 16;
  localparam int CNT_W = 22;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [1:0]       depthCode = 2'd0;
  logic [1:0]       widthCode = 2'd0;
  logic [CNT_W-1:0] pixCount = '0;
  logic             startPulse = 1'b0;
  logic             pixValid = 1'b0;
  logic [PIX_W-1:0] pixData = '0;
  logic             pixReady;
  logic             cmdValid = 1'b0;
  logic [BUS_W-1:0] cmdWord = '0;
  logic             parValid = 1'b0;
  logic [BUS_W-1:0] parWord = '0;
  logic             busWr;
  logic [BUS_W-1:0] busData;
  logic             busDc;
  logic             busy;
  logic             frameDone;
  logic             cfgErr;

  int    tests = 0;
  int    fails = 0;
  int    expData[$];
  bit    expDc[$];
  string curTag = "R13";
  int    doneCnt = 0;
  bit    prevWr = 1'b0;
  bit    finished = 1'b0;

  always #4 clk = ~clk;

  pix_bus_packer #(.PIX_W(PIX_W), .BUS_W(BUS_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .depthCode(depthCode), .widthCode(widthCode),
    .pixCount(pixCount), .startPulse(startPulse), .pixValid(pixValid),
    .pixData(pixData), .pixReady(pixReady), .cmdValid(cmdValid),
    .cmdWord(cmdWord), .parValid(parValid), .parWord(parWord),
    .busWr(busWr), .busData(busData), .busDc(busDc), .busy(busy),
    .frameDone(frameDone), .cfgErr(cfgErr)
  );

  function automatic int depthOf(int c);
    case (c) 0: return 12; 1: return 16; 2: return 18; default: return 24; endcase
  endfunction

  function automatic int widthOf(int c);
    case (c) 0: return 8; 1: return 9; 2: return 12; default: return 16; endcase
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // reference comparison on every clock
  int eWord;
  bit eDc;
  always @(negedge clk) begin
    if (rstN) begin
      if (busWr) begin
        if (expData.size() == 0) begin
          check(1'b0, curTag, "unexpected bus write", {busDc, busData}, 0);
        end else begin
          eWord = expData.pop_front();
          eDc   = expDc.pop_front();
          check({busDc, busData} == {eDc, eWord[15:0]}, curTag, "bus word",
                {busDc, busData}, {eDc, eWord[15:0]});
        end
      end
      if (frameDone) begin
        doneCnt++;
        check(prevWr && (expData.size() == 0) && !busy, "R7", "frame-done timing",
              {prevWr, busy}, 2);
      end
      prevWr = busWr;
    end
  end

  task automatic sendPix(int p, bit gap);
    bit got;
    pixValid = 1'b1;
    pixData  = p[PIX_W-1:0];
    forever begin
      got = pixReady;
      @(negedge clk);
      if (got) break;
    end
    pixValid = 1'b0;
    if (gap) @(negedge clk);
  endtask

  task automatic runFrame(string tag, int dc, int wc, int n, bit gap, bit mess);
    int d = depthOf(dc);
    int w = widthOf(wc);
    int pix[$];
    bit bits[$];
    int startDone;
    int t;
    curTag = tag;
    for (int i = 0; i < n; i++) pix.push_back(int'($urandom() & 32'h00FF_FFFF));
    foreach (pix[i]) for (int b = d - 1; b >= 0; b--) bits.push_back(pix[i][b]);
    if ((2 * d == 3 * w) && (n % 2 == 1)) repeat (d) bits.push_back(1'b0);
    while (bits.size() >= w) begin
      int word = 0;
      for (int k = 0; k < w; k++) word = (word << 1) | int'(bits.pop_front());
      expData.push_back(word);
      expDc.push_back(1'b1);
    end
    depthCode  = dc[1:0];
    widthCode  = wc[1:0];
    pixCount   = CNT_W'(n);
    startPulse = 1'b1;
    if (mess) begin cmdValid = 1'b1; cmdWord = 16'hBEEF; end
    @(negedge clk);
    startPulse = 1'b0;
    cmdValid   = 1'b0;
    check(busy == 1'b1, "R6", "busy after start", busy, 1);
    if (mess) begin
      // R11 strobes during a frame; R6 config changes during a frame
      depthCode = depthCode ^ 2'b01;
      widthCode = widthCode ^ 2'b10;
      pixCount  = CNT_W'(n + 3);
      cmdValid  = 1'b1;
      parValid  = 1'b1;
      @(negedge clk);
      cmdValid  = 1'b0;
      parValid  = 1'b0;
    end
    startDone = doneCnt;
    foreach (pix[i]) sendPix(pix[i], gap);
    t = 0;
    while ((doneCnt == startDone) && (t < 500)) begin @(negedge clk); t++; end
    check(doneCnt == startDone + 1, "R7", "one frame-done per frame", doneCnt - startDone, 1);
    check(expData.size() == 0, tag, "all words emitted", expData.size(), 0);
  endtask

  task automatic sendCmd(int wc, bit isParam, bit both, int word);
    int m = (1 << widthOf(wc)) - 1;
    curTag = "R10";
    widthCode = wc[1:0];
    expData.push_back(word & m);
    expDc.push_back(isParam && !both);
    cmdWord  = word[BUS_W-1:0];
    parWord  = word[BUS_W-1:0];
    cmdValid = !isParam || both;
    parValid = isParam || both;
    @(negedge clk);
    cmdValid = 1'b0;
    parValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(expData.size() == 0, "R10", "command word emitted", expData.size(), 0);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL R7 watchdog actual=hung expected=complete");
      finishRun();
    end
  end

  initial begin
    int d0;
    repeat (3) @(negedge clk);
    check({busWr, busy, frameDone, cfgErr, pixReady} == 5'b0, "R13", "outputs in reset",
          {busWr, busy, frameDone, cfgErr, pixReady}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check({busWr, busy, frameDone, cfgErr, pixReady} == 5'b0, "R13", "outputs after reset",
          {busWr, busy, frameDone, cfgErr, pixReady}, 0);

    sendCmd(0, 1'b0, 1'b0, 16'h01A5);
    sendCmd(3, 1'b1, 1'b0, 16'hCAFE);
    sendCmd(1, 1'b1, 1'b0, 16'hF3FF);
    sendCmd(3, 1'b1, 1'b1, 16'h7123);

    runFrame("R1", 1, 3, 3, 1'b0, 1'b0);
    runFrame("R1", 0, 2, 4, 1'b1, 1'b0);
    runFrame("R2", 1, 0, 3, 1'b0, 1'b0);
    runFrame("R2", 3, 0, 2, 1'b1, 1'b0);
    runFrame("R2", 2, 1, 3, 1'b0, 1'b0);
    runFrame("R2", 3, 2, 2, 1'b0, 1'b0);
    runFrame("R3", 0, 0, 4, 1'b0, 1'b0);
    runFrame("R3", 3, 3, 2, 1'b1, 1'b0);
    runFrame("R3", 2, 2, 6, 1'b0, 1'b0);
    runFrame("R4", 0, 0, 3, 1'b0, 1'b0);
    runFrame("R4", 3, 3, 1, 1'b1, 1'b0);
    runFrame("R5", 0, 2, 5, 1'b0, 1'b0);
    runFrame("R11", 1, 0, 4, 1'b0, 1'b1);
    check(cfgErr == 1'b0, "R8", "no error before bad start", cfgErr, 0);

    // R12 no handshake while idle
    check(pixReady == 1'b0, "R12", "ready low in idle", pixReady, 0);

    // R9 zero count
    curTag = "R9";
    d0 = doneCnt;
    depthCode = 2'd1; widthCode = 2'd3; pixCount = '0;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    repeat (4) @(negedge clk);
    check(busy == 1'b0, "R9", "zero count does not start", busy, 0);
    check(doneCnt == d0, "R9", "no frame-done on zero count", doneCnt - d0, 0);

    // R8 invalid pair: 18 bits on 8 lines
    curTag = "R8";
    depthCode = 2'd2; widthCode = 2'd0; pixCount = CNT_W'(4);
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    check(cfgErr == 1'b1, "R8", "error flag set", cfgErr, 1);
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R8", "no transfer on bad pair", busy, 0);
    check(pixReady == 1'b0, "R12", "ready low after refused start", pixReady, 0);
    runFrame("R8", 1, 3, 2, 1'b0, 1'b0);
    check(cfgErr == 1'b1, "R8", "error flag sticky", cfgErr, 1);

    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule